// File: doc/BRIEF.md
# SPI Display Register Slave

This block sits on the receiving end of a serial link from a clock controller and holds the values shown on a seven-segment display. It listens as an SPI slave in mode 0 and gathers whole bytes. Each byte marks itself with its top bit. A byte with the top bit set chooses which internal register is targeted next. A byte with the top bit clear is a value, and it is written into the chosen register. Because every byte marks its own kind, a slip in framing is corrected by the next addressing byte. The slave does not depend on where a byte falls inside a transfer.

There are sixteen 8-bit registers. The low-numbered registers are wired straight to per-digit outputs, so register 0 drives the leftmost digit (tens of hours). Whenever a register is written, a one-cycle strobe and the register index are raised. While selected, the slave returns on MISO the byte it received before the current one. SCLK, MOSI and chip select are sampled into the system clock domain, and clock edges are detected there. No logic runs on SCLK itself.

Top module: `disp_spi_regs`

## Requirements
- R1: Bits are captured on rising SCLK edges while chip select is low (SCLK idles low, mode 0), and the first bit of each byte is its most significant bit.
- R2: A received byte with bit 7 = 1 is an address: bits 3..0 become the current register index, bits 6..4 have no effect, and no register is written.
- R3: A received byte with bit 7 = 0 is stored whole into the register at the current index. The index is kept afterwards, so consecutive data bytes overwrite the same register.
- R4: Register k for k = 0..DIGITS-1 drives digit_o[8k+7:8k], and digit 0 is the tens-of-hours digit. A write to a register of index DIGITS or above leaves every digit output unchanged.
- R5: MISO carries, MSB first, the last completely received byte. It is valid before the first rising SCLK edge of a byte and changes after falling edges. It reads 0x00 until a byte has been received.
- R6: Chip select is active low. SCLK edges while it is high are ignored. Raising it in the middle of a byte discards the partial byte, so nothing is committed, and the next byte starts aligned.
- R7: Every data-byte write raises wr_stb for exactly one clock, with wr_idx equal to the register written. Address bytes raise no strobe.
- R8: A synchronous active-high reset clears the index to 0, all registers and digit outputs to 0x00, the echo byte to 0x00 and the strobe to low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the controller, idle low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_miso | output | 1 | Serial data to the controller (echo of previous byte) |
| digit_o | output | 8*DIGITS | Per-digit register values, digit k in bits 8k+7..8k |
| wr_stb | output | 1 | One-cycle pulse on every register write |
| wr_idx | output | IDX_W | Index of the register just written |

## Verification
The bench starts with address-then-data pairs whose values are not bit-palindromes, so a reversed bit order or a wrong sampling edge shows up as a wrong digit value. An address byte with its spare bits set is used to tell correct index extraction apart from use of the whole byte. Runs of data bytes with no new address show whether the index is kept. A write to a register above the digit range shows whether the digit mapping stays confined. Several bytes sent under one chip select, a transfer aborted after a few bits, and SCLK toggling while deselected separate the echo, abort and ignore behaviour from ordinary framing. A reset in the middle of operation followed by a bare data byte confirms that the index returned to zero.

// File: rtl/disp_spi_pkg.sv
package disp_spi_pkg;
  localparam int BYTE_W   = 8;
  localparam int FLAG_BIT = BYTE_W - 1;

  typedef logic [BYTE_W-1:0] spi_byte_t;

  function automatic logic is_addr(input spi_byte_t b);
    return b[FLAG_BIT];
  endfunction
endpackage

// File: rtl/disp_spi_sync.sv
module disp_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic mosi_i,
  input  logic cs_n_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_s,
  output logic cs_idle
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sclk_p, mosi_p, cs_p;
  logic              sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      mosi_p <= '0;
      cs_p   <= '1;
      sclk_d <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
      mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
      cs_p   <= {cs_p[STAGES-2:0], cs_n_i};
      sclk_d <= sclk_p[TOP];
    end
  end

  assign cs_idle   = cs_p[TOP];
  assign mosi_s    = mosi_p[TOP];
  assign sclk_rise =  sclk_p[TOP] & ~sclk_d & ~cs_p[TOP];
  assign sclk_fall = ~sclk_p[TOP] &  sclk_d & ~cs_p[TOP];
endmodule

// File: rtl/disp_spi_shifter.sv
module disp_spi_shifter
  import disp_spi_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sclk_rise,
  input  logic      sclk_fall,
  input  logic      mosi_s,
  input  logic      cs_idle,
  output logic      byte_done,
  output spi_byte_t rx_byte,
  output logic      miso
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] bit_cnt;
  spi_byte_t        rx_sh, tx_sh, tx_hold, rx_next;

  assign rx_next = {rx_sh[BYTE_W-2:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      tx_hold   <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (cs_idle) begin
        bit_cnt <= '0;
        tx_sh   <= tx_hold;
      end else if (sclk_rise) begin
        rx_sh   <= rx_next;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          bit_cnt   <= '0;
          byte_done <= 1'b1;
          rx_byte   <= rx_next;
          tx_hold   <= rx_next;
          tx_sh     <= rx_next;
        end
      end else if (sclk_fall && bit_cnt != '0) begin
        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign miso = tx_sh[BYTE_W-1];
endmodule

// File: rtl/disp_spi_regfile.sv
module disp_spi_regfile
  import disp_spi_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DIGITS = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       byte_done,
  input  spi_byte_t                  rx_byte,
  output logic [IDX_W-1:0]           cur_idx,
  output logic                       wr_stb,
  output logic [IDX_W-1:0]           wr_idx,
  output logic [DIGITS*BYTE_W-1:0]   digit_o
);
  localparam int NREG = 1 << IDX_W;

  spi_byte_t regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx <= '0;
      wr_stb  <= 1'b0;
      wr_idx  <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (byte_done) begin
        if (is_addr(rx_byte)) begin
          cur_idx <= rx_byte[IDX_W-1:0];
        end else begin
          regs[cur_idx] <= rx_byte;
          wr_stb        <= 1'b1;
          wr_idx        <= cur_idx;
        end
      end
    end
  end

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    assign digit_o[d*BYTE_W +: BYTE_W] = regs[d];
  end
endmodule

// File: rtl/disp_spi_regs.sv
module disp_spi_regs
  import disp_spi_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter int DIGITS      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     spi_sclk,
  input  logic                     spi_mosi,
  input  logic                     spi_cs_n,
  output logic                     spi_miso,
  output logic [DIGITS*BYTE_W-1:0] digit_o,
  output logic                     wr_stb,
  output logic [IDX_W-1:0]         wr_idx
);
  logic       sclk_rise, sclk_fall, mosi_s, cs_idle;
  logic       byte_done;
  spi_byte_t  rx_byte;
  logic [IDX_W-1:0] cur_idx;

  disp_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .sclk_i(spi_sclk), .mosi_i(spi_mosi), .cs_n_i(spi_cs_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .mosi_s(mosi_s), .cs_idle(cs_idle)
  );

  disp_spi_shifter u_shift (
    .clk(clk), .rst(rst),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .mosi_s(mosi_s), .cs_idle(cs_idle),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  disp_spi_regfile #(.IDX_W(IDX_W), .DIGITS(DIGITS)) u_regs (
    .clk(clk), .rst(rst),
    .byte_done(byte_done), .rx_byte(rx_byte),
    .cur_idx(cur_idx), .wr_stb(wr_stb), .wr_idx(wr_idx),
    .digit_o(digit_o)
  );
endmodule

// File: rtl/disp_spi_regs_chk.sv
module disp_spi_regs_chk
  import disp_spi_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DIGITS = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cs_idle,
  input logic                     byte_done,
  input spi_byte_t                rx_byte,
  input logic [IDX_W-1:0]         cur_idx,
  input logic                     wr_stb,
  input logic [IDX_W-1:0]         wr_idx,
  input logic [DIGITS*BYTE_W-1:0] digit_o,
  input logic                     spi_miso
);
  // R7: strobe lasts one cycle
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R2: address bytes write nothing
  assert_addr_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    (byte_done && rx_byte[FLAG_BIT]) |=> !wr_stb);

  // R3: data bytes write at the index held when they arrived
  assert_data_write_R3: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !rx_byte[FLAG_BIT]) |=> (wr_stb && wr_idx == $past(cur_idx)));

  // R4: digit outputs move only together with a write strobe
  assert_digit_on_write_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(digit_o)) |-> wr_stb);

  // R6: no byte completes from a deselected cycle
  assert_idle_no_byte_R6: assert property (@(posedge clk) disable iff (rst)
    $past(cs_idle) |-> !byte_done);

  // R8: echo output is zero right after reset
  assert_miso_reset_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !spi_miso);
endmodule

bind disp_spi_regs disp_spi_regs_chk #(.IDX_W(IDX_W), .DIGITS(DIGITS)) u_chk (
  .clk(clk), .rst(rst), .cs_idle(cs_idle), .byte_done(byte_done),
  .rx_byte(rx_byte), .cur_idx(cur_idx), .wr_stb(wr_stb), .wr_idx(wr_idx),
  .digit_o(digit_o), .spi_miso(spi_miso)
);

// File: tb/test_disp_spi_regs.sv
module test_disp_spi_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int DIGITS     = 6;
  localparam int IDX_W      = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
  logic spi_miso;
  logic [DIGITS*8-1:0] digit_o;
  logic wr_stb;
  logic [IDX_W-1:0] wr_idx;

  int checks = 0, errors = 0;
  int stb_cnt = 0;
  logic [IDX_W-1:0] last_idx = '0;
  logic [7:0] exp_dig [DIGITS];

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_spi_regs #(.IDX_W(IDX_W), .DIGITS(DIGITS), .SYNC_STAGES(2)) i_disp_spi_regs (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .digit_o(digit_o),
    .wr_stb(wr_stb), .wr_idx(wr_idx)
  );

  always @(negedge clk) begin
    if (wr_stb) begin
      stb_cnt  <= stb_cnt + 1;
      last_idx <= wr_idx;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_digits(input string req);
    for (int d = 0; d < DIGITS; d++)
      check(req, 32'(digit_o[d*8 +: 8]), 32'(exp_dig[d]));
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(2*HALF);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      spi_mosi = tx[i];
      wait_clk(HALF);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    bits(tx, 8, rx);
  endtask

  task automatic put(input logic [7:0] tx);
    logic [7:0] rx;
    xfer(tx, rx);
  endtask

  task automatic t_reset();
    check("R8 miso after reset", 32'(spi_miso), 0);
    check("R8 strobe count", stb_cnt, 0);
    check_digits("R8 digits after reset");
  endtask

  task automatic t_basic();
    int s0 = stb_cnt;
    sel(); put(8'h80); put(8'h12); desel();
    exp_dig[0] = 8'h12;
    check_digits("R1 R3 R4 digit0 msb-first");
    check("R7 one strobe", stb_cnt - s0, 1);
    check("R7 strobe index", 32'(last_idx), 0);
  endtask

  task automatic t_addr_upper();
    int s0 = stb_cnt;
    sel(); put(8'hF3); desel();
    check("R2 address gives no strobe", stb_cnt - s0, 0);
    check_digits("R2 address writes nothing");
    sel(); put(8'h34); desel();
    exp_dig[3] = 8'h34;
    check_digits("R2 bits 6..4 ignored");
    check("R2 index 3", 32'(last_idx), 3);
  endtask

  task automatic t_index_hold();
    int s0 = stb_cnt;
    sel(); put(8'h85); put(8'h11); put(8'h22); desel();
    exp_dig[5] = 8'h22;
    check_digits("R3 index kept, overwrite");
    check("R3 two strobes", stb_cnt - s0, 2);
  endtask

  task automatic t_nondigit();
    sel(); put(8'h8A); put(8'h7F); desel();
    check_digits("R4 high register leaves digits");
    check("R7 index 10", 32'(last_idx), 10);
  endtask

  task automatic t_echo();
    logic [7:0] r0, r1, r2;
    sel(); xfer(8'h81, r0); xfer(8'h23, r1); xfer(8'h45, r2); desel();
    check("R5 echo first byte", 32'(r0), 32'h7F);
    check("R5 echo second byte", 32'(r1), 32'h81);
    check("R5 echo third byte", 32'(r2), 32'h23);
    exp_dig[1] = 8'h45;
    check_digits("R3 digit1 after echo run");
  endtask

  task automatic t_abort();
    logic [7:0] r;
    int s0 = stb_cnt;
    sel(); bits(8'h0F, 5, r); desel();
    check("R6 partial byte no strobe", stb_cnt - s0, 0);
    check_digits("R6 partial byte no write");
    sel(); xfer(8'h66, r); desel();
    exp_dig[1] = 8'h66;
    check_digits("R6 realigned after abort");
    check("R5 R6 echo unaffected by partial", 32'(r), 32'h45);
  endtask

  task automatic t_idle_clock();
    int s0 = stb_cnt;
    for (int i = 0; i < 10; i++) begin
      spi_mosi = i[0];
      wait_clk(HALF); spi_sclk = 1'b1;
      wait_clk(HALF); spi_sclk = 1'b0;
    end
    wait_clk(2*HALF);
    check("R6 idle clock no strobe", stb_cnt - s0, 0);
    check_digits("R6 idle clock no write");
  endtask

  task automatic t_reset_mid();
    wait_clk(1); rst = 1'b1; wait_clk(2); rst = 1'b0; wait_clk(2);
    for (int d = 0; d < DIGITS; d++) exp_dig[d] = '0;
    check_digits("R8 mid-run reset clears digits");
    check("R8 miso cleared", 32'(spi_miso), 0);
    sel(); put(8'h09); desel();
    exp_dig[0] = 8'h09;
    check_digits("R8 index back to 0");
  endtask

  initial begin
    for (int d = 0; d < DIGITS; d++) exp_dig[d] = '0;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    fork
      begin
        t_reset();
        t_basic();
        t_addr_upper();
        t_index_hold();
        t_nondigit();
        t_echo();
        t_abort();
        t_idle_clock();
        t_reset_mid();
      end
      begin
        wait_clk(150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule